// File: doc/BRIEF.md
# Double/Single-Rate Burst Memory Front End

This block sits at the front of a synchronous pipelined memory. It samples an address and three active-low strobes on every rising clock edge. A load cycle starts a new four-word burst at the supplied base address. The two low address bits give the starting position in the burst. Continuation cycles, with load high, step through the rest of the burst in either linear or interleaved order. A small register-file array is included so that the path can be exercised end to end.

Read data for a captured address appears on the following edge. In single-rate mode one word is returned per cycle on lane 0. In double-rate mode a second word, taken from the next burst-order address, is returned on lane 1 in the same cycle. Lane 1 stands for the beat that would follow at the falling edge. Each lane has its own valid flag, so the whole design runs on one clock.

Writes work the same way but one cycle late. The data words arrive on the write-data lanes in the cycles after the load. The rate and order chosen on the load stay in force for the whole burst.

Top module: `ddr_burst_front`

## Requirements
- R1: While reset is asserted, and after its release until a read has been loaded, both valid flags `rvld0_o` and `rvld1_o` are low.
- R2: A cycle with `load_n`=0 and `write_n`=1 starts a read. At the next rising edge, `rdata0_o` holds the word at the base address and `rvld0_o` is 1.
- R3: With `rate_n`=0 at the load (double rate), each output cycle carries two words. Lane 1 holds the next burst-order address and has `rvld1_o`=1. The four-word burst is delivered over two cycles.
- R4: With `rate_n`=1 at the load (single rate), each output cycle carries one word with `rvld1_o`=0. The burst is delivered over four cycles.
- R5: With `order_i`=0 at the load, burst word k (k=0..3) is at address bits [1:0] = (base[1:0]+k) mod 4. Upper address bits are unchanged.
- R6: With `order_i`=1 at the load, burst word k is at address bits [1:0] = base[1:0] XOR k. Upper address bits are unchanged.
- R7: A load with `write_n`=0 starts a write burst of the same shape. In each following cycle, `wdata0_i` (and `wdata1_i` in double rate) is stored at the current burst word(s). No valid flag rises for a write burst.
- R8: `rate_n` is ignored on continuation cycles. The burst keeps the rate latched at its load.
- R9: Once the four words of a burst are used, further continuation cycles produce no valid output.
- R10: A load during an unfinished burst abandons it. The next output is from the new base address.
- R11: A read loaded on the same edge that stores the last word of a write burst returns the new data.
- R12: `order_i` is ignored on continuation cycles. The burst keeps the order latched at its load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address, sampled on load cycles |
| load_n | input | 1 | Active-low load; high means continue the current burst |
| write_n | input | 1 | Active-low write select, sampled on load |
| rate_n | input | 1 | 0 selects double rate, 1 selects single rate; sampled on load |
| order_i | input | 1 | 1 selects interleaved order, 0 selects linear; sampled on load |
| wdata0_i | input | DW | Write word for the current burst position |
| wdata1_i | input | DW | Write word for the next burst position (double rate) |
| rdata0_o | output | DW | First read beat |
| rdata1_o | output | DW | Second read beat (double rate) |
| rvld0_o | output | 1 | First beat valid |
| rvld1_o | output | 1 | Second beat valid |

## Verification
The array is first filled with double-rate linear write bursts, so that every read can be predicted. Reads are then loaded at starting positions 1, 2 and 3, which is where linear and interleaved order give different addresses. Each order is tried at both rates, so the tests can tell a wrong address sequence apart from a wrong beat count. In a further burst the rate and order inputs are toggled on continuation cycles, to show that only load cycles set them. Directed sequences cover:
- a burst cut short by a new load,
- a read loaded on the edge of the last write beat,
- continuation past the end of a burst.

A long run of mixed random loads and continuations follows.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  localparam int BURST_BITS = 2;

  // Address bits [1:0] of burst word k for a given start position.
  function automatic logic [BURST_BITS-1:0] burst_pos(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] k,
    input logic                  ilv
  );
    return ilv ? (start ^ k) : (start + k);
  endfunction
endpackage

// File: rtl/ddrb_seq.sv
module ddrb_seq
  import ddrb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          write_n,
  input  logic          rate_n,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic          act_o,
  output logic          wr_o,
  output logic          ddr_o,
  output logic [AW-1:0] wa0_o,
  output logic [AW-1:0] wa1_o
);
  localparam int UW = AW - BURST_BITS;

  logic                  act_q, act_d;
  logic                  wr_q, wr_d;
  logic                  ddr_q, ddr_d;
  logic                  ilv_q, ilv_d;
  logic [AW-1:0]         base_q, base_d;
  logic [BURST_BITS-1:0] cnt_q, cnt_d;
  logic [BURST_BITS:0]   cnt_sum;

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    ddr_d   = ddr_q;
    ilv_d   = ilv_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    cnt_sum = {1'b0, cnt_q} + (ddr_q ? 3'd2 : 3'd1);
    if (!load_n) begin
      act_d  = 1'b1;
      wr_d   = !write_n;
      ddr_d  = !rate_n;
      ilv_d  = order_i;
      base_d = addr_i;
      cnt_d  = '0;
    end else if (act_q) begin
      cnt_d = cnt_sum[BURST_BITS-1:0];
      if (cnt_sum[BURST_BITS]) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ddr_q  <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q <= act_d;
      if (!load_n) begin
        wr_q   <= wr_d;
        ddr_q  <= ddr_d;
        ilv_q  <= ilv_d;
        base_q <= base_d;
      end
      if (!load_n || act_q) cnt_q <= cnt_d;
    end
  end

  assign act_o = act_q;
  assign wr_o  = wr_q;
  assign ddr_o = ddr_q;
  assign wa0_o = {base_q[AW-1:BURST_BITS],
                  burst_pos(base_q[BURST_BITS-1:0], cnt_q, ilv_q)};
  assign wa1_o = {base_q[AW-1:BURST_BITS],
                  burst_pos(base_q[BURST_BITS-1:0], cnt_q + 2'd1, ilv_q)};

  // R2
  load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (act_q && cnt_q == '0));
  // R3
  ddr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ddr_q) |-> (cnt_q[0] == 1'b0));
  // R4
  sdr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !ddr_q && load_n && cnt_q != 2'd3) |=>
      (act_q && cnt_q == $past(cnt_q) + 2'd1));
  // R9
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && load_n && ((ddr_q && cnt_q == 2'd2) || (!ddr_q && cnt_q == 2'd3)))
      |=> !act_q);
  // R8
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> (ddr_q == $past(ddr_q)));
  // R12
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> (ilv_q == $past(ilv_q)));
endmodule

// File: rtl/ddrb_rf.sv
module ddrb_rf #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/ddr_burst_front.sv
module ddr_burst_front #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          load_n,
  input  logic          write_n,
  input  logic          rate_n,
  input  logic          order_i,
  input  logic [DW-1:0] wdata0_i,
  input  logic [DW-1:0] wdata1_i,
  output logic [DW-1:0] rdata0_o,
  output logic [DW-1:0] rdata1_o,
  output logic          rvld0_o,
  output logic          rvld1_o
);
  logic          act, wr, ddr;
  logic [AW-1:0] wa0, wa1;
  logic [DW-1:0] arr0, arr1;
  logic          rd_go, rd_go2;
  logic          vld0_d, vld1_d;

  ddrb_seq #(.AW(AW)) i_seq (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .write_n(write_n),
    .rate_n(rate_n), .order_i(order_i), .addr_i(addr_i),
    .act_o(act), .wr_o(wr), .ddr_o(ddr), .wa0_o(wa0), .wa1_o(wa1)
  );

  ddrb_rf #(.AW(AW), .DW(DW)) i_rf (
    .clk(clk),
    .we0(act && wr), .wa0(wa0), .wd0(wdata0_i),
    .we1(act && wr && ddr), .wa1(wa1), .wd1(wdata1_i),
    .ra0(wa0), .ra1(wa1), .rd0(arr0), .rd1(arr1)
  );

  always_comb begin
    rd_go  = act && !wr;
    rd_go2 = rd_go && ddr;
    vld0_d = rd_go;
    vld1_d = rd_go2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld0_o  <= 1'b0;
      rvld1_o  <= 1'b0;
      rdata0_o <= '0;
      rdata1_o <= '0;
    end else begin
      rvld0_o <= vld0_d;
      rvld1_o <= vld1_d;
      if (rd_go)  rdata0_o <= arr0;
      if (rd_go2) rdata1_o <= arr1;
    end
  end

  // R3
  lane1_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvld1_o |-> rvld0_o);
  // R7
  no_write_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvld0_o |-> $past(act && !wr));
  // R4
  sdr_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !wr && !ddr) |=> !rvld1_o);
endmodule

// File: tb/test_ddr_burst_front.sv
module test_ddr_burst_front;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          load_n, write_n, rate_n, order_i;
  logic [DW-1:0] wdata0_i, wdata1_i;
  logic [DW-1:0] rdata0_o, rdata1_o;
  logic          rvld0_o, rvld1_o;

  always #4 clk = ~clk;

  ddr_burst_front #(.AW(AW), .DW(DW)) i_ddr_burst_front (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .load_n(load_n),
    .write_n(write_n), .rate_n(rate_n), .order_i(order_i),
    .wdata0_i(wdata0_i), .wdata1_i(wdata1_i),
    .rdata0_o(rdata0_o), .rdata1_o(rdata1_o),
    .rvld0_o(rvld0_o), .rvld1_o(rvld1_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [DW-1:0] mmem [64];
  bit    m_act = 0, m_wr = 0, m_ddr = 0, m_ilv = 0;
  int    m_base = 0, m_cnt = 0;
  bit    exp_v0 = 0, exp_v1 = 0;
  logic [DW-1:0] exp_d0 = '0, exp_d1 = '0;
  string exp_tag = "R1";

  function automatic int word_addr(int k);
    int lo;
    lo = m_ilv ? ((m_base & 3) ^ k) : ((m_base + k) & 3);
    return (m_base & ~3) | lo;
  endfunction

  task automatic check();
    bit bad;
    n_vec++;
    bad = (rvld0_o !== exp_v0) || (rvld1_o !== exp_v1) ||
          (exp_v0 && rdata0_o !== exp_d0) || (exp_v1 && rdata1_o !== exp_d1);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got v0=%b v1=%b d0=%h d1=%h, expected v0=%b v1=%b d0=%h d1=%h",
               exp_tag, rvld0_o, rvld1_o, rdata0_o, rdata1_o,
               exp_v0, exp_v1, exp_d0, exp_d1);
    end
  endtask

  task automatic cyc(input bit ld, input bit wr, input bit rt, input bit il,
                     input int a, input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                     input string tag);
    @(negedge clk);
    check();
    load_n = ld; write_n = wr; rate_n = rt; order_i = il;
    addr_i = AW'(a); wdata0_i = w0; wdata1_i = w1;
    exp_v0 = m_act && !m_wr;
    exp_v1 = m_act && !m_wr && m_ddr;
    if (exp_v0) exp_d0 = mmem[word_addr(m_cnt)];
    if (exp_v1) exp_d1 = mmem[word_addr(m_cnt + 1)];
    if (m_act && m_wr) begin
      mmem[word_addr(m_cnt)] = w0;
      if (m_ddr) mmem[word_addr(m_cnt + 1)] = w1;
    end
    if (!ld) begin
      m_act = 1; m_wr = !wr; m_ddr = !rt; m_ilv = il; m_base = a; m_cnt = 0;
    end else if (m_act) begin
      m_cnt = m_cnt + (m_ddr ? 2 : 1);
      if (m_cnt >= 4) m_act = 0;
    end
    exp_tag = tag;
  endtask

  task automatic idle(input string tag);
    cyc(1, 1, 1, 0, 0, '0, '0, tag);
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return 16'hA000 ^ DW'(i * 16'h0137);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_n = 1; write_n = 1; rate_n = 1; order_i = 0;
    addr_i = '0; wdata0_i = '0; wdata1_i = '0;
    repeat (2) @(negedge clk);
    check();                                       // R1 during reset
    rst_n = 1'b1;
    repeat (3) idle("R1");
    // R7: fill the array with double-rate linear write bursts
    for (int b = 0; b < 16; b++) begin
      cyc(0, 0, 0, 0, b * 4, '0, '0, "R7");
      cyc(1, 1, 1, 0, 0, pat(b * 4), pat(b * 4 + 1), "R7");
      cyc(1, 1, 1, 0, 0, pat(b * 4 + 2), pat(b * 4 + 3), "R7");
    end
    idle("R7");
    // R4 R5 R2: single rate linear from position 2, then R9 tail
    cyc(0, 1, 1, 0, 6, '0, '0, "R2");
    repeat (3) idle("R5");
    repeat (3) idle("R9");
    // R3 R6: double rate interleaved from position 1
    cyc(0, 1, 0, 1, 13, '0, '0, "R6");
    repeat (3) idle("R3");
    // R6 at single rate, position 3
    cyc(0, 1, 1, 1, 39, '0, '0, "R6");
    repeat (4) idle("R4");
    // R8 R12: toggle rate and order on continuation cycles
    cyc(0, 1, 1, 0, 50, '0, '0, "R8");
    cyc(1, 1, 0, 1, 0, '0, '0, "R8");
    cyc(1, 1, 0, 1, 0, '0, '0, "R12");
    cyc(1, 1, 0, 1, 0, '0, '0, "R12");
    idle("R8");
    // R10: new load abandons unfinished burst
    cyc(0, 1, 1, 0, 21, '0, '0, "R10");
    idle("R10");
    cyc(0, 1, 0, 0, 43, '0, '0, "R10");
    repeat (3) idle("R10");
    // R11: single-rate interleaved write, read loaded on last write beat
    cyc(0, 0, 1, 1, 30, '0, '0, "R7");
    cyc(1, 1, 1, 0, 0, 16'h1111, '0, "R7");
    cyc(1, 1, 1, 0, 0, 16'h2222, '0, "R7");
    cyc(1, 1, 1, 0, 0, 16'h3333, '0, "R7");
    cyc(0, 1, 0, 0, 28, 16'h4444, '0, "R11");
    repeat (3) idle("R11");
    // R2: mixed random traffic
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 3) != 0, ($urandom % 3) != 0, $urandom % 2, $urandom % 2,
          $urandom % 64, DW'($urandom), DW'($urandom), "R2");
    end
    repeat (4) idle("R9");
    @(negedge clk);
    check();
    finish_run();
  end
endmodule